// File: doc/BRIEF.md
# Byte-Serial Square-Plus-Multiple Encryptor

This block produces the ciphertext M = P·P + R·N without any modular reduction. The plaintext P is built by concatenating a short reader challenge (most significant), a random pad and a stored identifier. R is a long random multiplier and N is the public modulus. All three operands are captured into internal registers by a single-cycle `start` pulse.

The product is formed column by column: for output byte k, every byte pair whose indices sum to k is multiplied (one 8×8 product per clock) and added into an accumulator that already holds the carry from column k−1. The low byte of the accumulator is then presented on a valid/ready byte stream. The upper bits are kept as the carry for the next column. Bytes leave least significant first. A byte is computed only after the previous one has been accepted, so the engine is never more than one byte ahead of the consumer.

Back-pressure rules: `out_valid` is raised when a byte is ready. While `out_ready` is low, `out_valid` and `out_byte` hold steady. A byte is transferred on a clock edge where both are high. The consumer may hold `out_ready` high at any time. `start` has priority over a pending transfer and restarts the computation from byte 0.

Top module: `sq_mul_encryptor`

## Requirements
- R1: The plaintext is {challenge, pad, ident}, with the challenge in the top CH_W bits and the identifier in the bottom ID_W bits. The pad width is N_W − CH_W − ID_W.
- R2: Output byte k (counting from 0) equals bits [8k+7:8k] of P·P + R·N, computed without reduction. There are exactly R_W/4 bytes, least significant first (276 bytes with default widths).
- R3: During and right after reset, `out_valid` and `done` are low.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` keeps its value. A byte is consumed only on a cycle with both high.
- R5: `done` rises in the cycle after the last byte is accepted. It then stays high with `out_valid` low until the next `start`.
- R6: A `start` pulse captures all operands and clears the carry, even in the middle of a stream. Operand inputs changed after the pulse have no effect on the bytes produced.
- R7: Carries propagate across all columns, so all-ones operands still give the exact sum.
- R8: Byte indices beyond an operand's length contribute zero, so the bytes above the highest product column come out as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle pulse: capture operands and begin at byte 0 |
| challenge | input | CH_W | Reader challenge, upper part of P |
| pad | input | N_W−CH_W−ID_W | Random pad, middle part of P |
| ident | input | ID_W | Identifier, lower part of P |
| rand_mul | input | R_W | Random multiplier R |
| modulus | input | N_W | Public modulus N |
| out_valid | output | 1 | Ciphertext byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Ciphertext byte |
| done | output | 1 | All ciphertext bytes have been delivered |

## Verification
The stream assertions assume that `start` is a one-cycle pulse. They also assume that the consumer does not rely on a byte held across a `start`, because the hold property excludes cycles where `start` is high. The bench honours this by keeping `out_ready` low whenever it pulses `start`. It draws the operands at random across their full widths and also uses all-zero, all-ones and single-field patterns. Ready is toggled at random to exercise stalls, and one run restarts in the middle of a stream.

// File: rtl/sqenc_pkg.sv
package sqenc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_MAC,
    ST_EMIT,
    ST_DONE
  } sq_state_e;

  typedef enum logic {
    PH_SQ,
    PH_RN
  } sq_phase_e;
endpackage

// File: rtl/sqenc_span.sv
// Index range of the first operand for one convolution column.
// Pairs (i, col-i) with i < LA and col-i < LB.
module sqenc_span #(
  parameter int LA = 128,
  parameter int LB = 128,
  parameter int CW = 10
) (
  input  logic [CW-1:0] col,
  output logic [CW-1:0] lo,
  output logic [CW-1:0] hi,
  output logic          ok
);
  localparam logic [CW-1:0] AMAX = CW'(LA - 1);
  localparam logic [CW-1:0] BMAX = CW'(LB - 1);

  always_comb begin
    lo = (col > BMAX) ? (col - BMAX) : '0;
    hi = (col < AMAX) ? col : AMAX;
    ok = (lo <= hi);
  end
endmodule

// File: rtl/sqenc_opsel.sv
// Picks the two operand bytes for the current pair.
module sqenc_opsel
  import sqenc_pkg::*;
#(
  parameter int NPB = 128,
  parameter int NRB = 138,
  parameter int NNB = 128,
  parameter int CW  = 10
) (
  input  logic [NPB*8-1:0] p_q,
  input  logic [NRB*8-1:0] r_q,
  input  logic [NNB*8-1:0] n_q,
  input  sq_phase_e        ph,
  input  logic [CW-1:0]    idx,
  input  logic [CW-1:0]    col,
  output logic [7:0]       a_byte,
  output logic [7:0]       b_byte
);
  logic [CW-1:0] jdx;
  logic [7:0] pa, pb, ra, nb;

  assign jdx = col - idx;

  always_comb begin
    pa = '0;
    pb = '0;
    for (int k = 0; k < NPB; k++) begin
      if (idx == CW'(k)) pa = p_q[k*8 +: 8];
      if (jdx == CW'(k)) pb = p_q[k*8 +: 8];
    end
  end

  always_comb begin
    ra = '0;
    for (int k = 0; k < NRB; k++)
      if (idx == CW'(k)) ra = r_q[k*8 +: 8];
  end

  always_comb begin
    nb = '0;
    for (int k = 0; k < NNB; k++)
      if (jdx == CW'(k)) nb = n_q[k*8 +: 8];
  end

  assign a_byte = (ph == PH_SQ) ? pa : ra;
  assign b_byte = (ph == PH_SQ) ? pb : nb;
endmodule

// File: rtl/sq_mul_encryptor.sv
module sq_mul_encryptor
  import sqenc_pkg::*;
#(
  parameter int CH_W  = 80,
  parameter int ID_W  = 864,
  parameter int N_W   = 1024,
  parameter int R_W   = 1104,
  parameter int ACC_W = 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CH_W-1:0]           challenge,
  input  logic [N_W-CH_W-ID_W-1:0]  pad,
  input  logic [ID_W-1:0]           ident,
  input  logic [R_W-1:0]            rand_mul,
  input  logic [N_W-1:0]            modulus,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [7:0]                out_byte,
  output logic                      done
);
  localparam int NPB       = N_W / 8;
  localparam int NNB       = N_W / 8;
  localparam int NRB       = R_W / 8;
  localparam int OUT_BYTES = R_W / 4;
  localparam int CW        = $clog2(OUT_BYTES) + 1;
  localparam logic [CW-1:0] LAST_COL = CW'(OUT_BYTES - 1);

  sq_state_e        st;
  sq_phase_e        ph;
  logic [CW-1:0]    idx, col;
  logic [ACC_W-1:0] acc;
  logic [N_W-1:0]   p_q, n_q;
  logic [R_W-1:0]   r_q;

  logic [CW-1:0] sq_lo, sq_hi, rn_lo, rn_hi;
  logic          sq_ok, rn_ok;
  logic [7:0]    a_byte, b_byte;
  logic [15:0]   prod;

  sqenc_span #(.LA(NPB), .LB(NPB), .CW(CW)) u_span_sq (
    .col(col), .lo(sq_lo), .hi(sq_hi), .ok(sq_ok)
  );

  sqenc_span #(.LA(NRB), .LB(NNB), .CW(CW)) u_span_rn (
    .col(col), .lo(rn_lo), .hi(rn_hi), .ok(rn_ok)
  );

  sqenc_opsel #(.NPB(NPB), .NRB(NRB), .NNB(NNB), .CW(CW)) u_opsel (
    .p_q(p_q), .r_q(r_q), .n_q(n_q), .ph(ph), .idx(idx), .col(col),
    .a_byte(a_byte), .b_byte(b_byte)
  );

  assign prod = {8'd0, a_byte} * {8'd0, b_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ph  <= PH_SQ;
      idx <= '0;
      col <= '0;
      acc <= '0;
      p_q <= '0;
      r_q <= '0;
      n_q <= '0;
    end else if (start) begin
      p_q <= {challenge, pad, ident};
      r_q <= rand_mul;
      n_q <= modulus;
      acc <= '0;
      col <= '0;
      idx <= '0;
      ph  <= PH_SQ;
      st  <= ST_ENTRY;
    end else begin
      case (st)
        ST_ENTRY: begin
          if (sq_ok) begin
            ph  <= PH_SQ;
            idx <= sq_lo;
            st  <= ST_MAC;
          end else if (rn_ok) begin
            ph  <= PH_RN;
            idx <= rn_lo;
            st  <= ST_MAC;
          end else begin
            st <= ST_EMIT;
          end
        end
        ST_MAC: begin
          acc <= acc + ACC_W'(prod);
          if (ph == PH_SQ) begin
            if (idx == sq_hi) begin
              if (rn_ok) begin
                ph  <= PH_RN;
                idx <= rn_lo;
              end else begin
                st <= ST_EMIT;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            if (idx == rn_hi) st <= ST_EMIT;
            else              idx <= idx + 1'b1;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            acc <= acc >> 8;
            col <= col + 1'b1;
            st  <= (col == LAST_COL) ? ST_DONE : ST_ENTRY;
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign out_valid = (st == ST_EMIT);
  assign out_byte  = acc[7:0];
  assign done      = (st == ST_DONE);
endmodule

// File: rtl/sqenc_chk.sv
module sqenc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       done
);
  // R3
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!out_valid && !done);
    end
  end

  // R4
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_byte));

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R5
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready));

  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !out_valid);
endmodule

bind sq_mul_encryptor sqenc_chk u_sqenc_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .done(done)
);

// File: tb/test_sq_mul_encryptor.sv
module test_sq_mul_encryptor;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W  = 8;
  localparam int ID_W  = 8;
  localparam int N_W   = 32;
  localparam int R_W   = 40;
  localparam int PAD_W = N_W - CH_W - ID_W;
  localparam int OUT_BYTES = R_W / 4;
  localparam int M_W   = 2 * R_W;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start = 1'b0;
  logic [CH_W-1:0]  challenge = '0;
  logic [PAD_W-1:0] pad = '0;
  logic [ID_W-1:0]  ident = '0;
  logic [R_W-1:0]   rand_mul = '0;
  logic [N_W-1:0]   modulus = '0;
  logic             out_valid, out_ready, done;
  logic [7:0]       out_byte;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sq_mul_encryptor #(.CH_W(CH_W), .ID_W(ID_W), .N_W(N_W), .R_W(R_W)) i_sq_mul_encryptor (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge), .pad(pad),
    .ident(ident), .rand_mul(rand_mul), .modulus(modulus), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .done(done)
  );

  function automatic logic [M_W-1:0] model(input logic [CH_W-1:0] c, input logic [PAD_W-1:0] p,
                                           input logic [ID_W-1:0] d, input logic [R_W-1:0] r,
                                           input logic [N_W-1:0] n);
    logic [M_W-1:0] pt;
    pt = M_W'({c, p, d});
    return pt * pt + M_W'(r) * M_W'(n);
  endfunction

  task automatic chk(input string req, input logic [M_W-1:0] act, input logic [M_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [CH_W-1:0] c, input logic [PAD_W-1:0] p, input logic [ID_W-1:0] d,
                      input logic [R_W-1:0] r, input logic [N_W-1:0] n);
    @(negedge clk);
    out_ready = 1'b0;
    challenge = c; pad = p; ident = d; rand_mul = r; modulus = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input logic [M_W-1:0] exp, input int pct, input string req, input int nbytes);
    int got = 0;
    int guard = 0;
    bit held_v = 0;
    logic [7:0] held = '0;
    while (got < nbytes && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (held_v && out_valid) chk("R4 hold", M_W'(out_byte), M_W'(held));
      out_ready = ($urandom_range(99) < pct);
      held_v = out_valid && !out_ready;
      held = out_byte;
      if (out_valid && out_ready) begin
        chk(req, M_W'(out_byte), M_W'(exp[got*8 +: 8]));
        got++;
      end
    end
    if (guard >= 3000) chk("watchdog stream", M_W'(got), M_W'(nbytes));
    if (nbytes == OUT_BYTES) begin
      @(negedge clk);
      out_ready = 1'b0;
      chk("R5 done raised", M_W'({done, out_valid}), M_W'(2'b10));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [M_W-1:0] e;
    logic [CH_W-1:0] c; logic [PAD_W-1:0] p; logic [ID_W-1:0] d;
    logic [R_W-1:0] r; logic [N_W-1:0] n;
    void'($urandom(32'h5EED_0A11));
    out_ready = 1'b0;
    #2 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 in reset", M_W'({out_valid, done}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 after reset", M_W'({out_valid, done}), '0);

    // R2 all zero operands
    kick('0, '0, '0, '0, '0);
    collect('0, 100, "R2 zeros", OUT_BYTES);

    // R7 / R8 all ones: carries across every column, top bytes zero
    kick('1, '1, '1, '1, '1);
    collect(model('1, '1, '1, '1, '1), 100, "R7 R8 all ones", OUT_BYTES);

    // R1 challenge only sits in the top byte of P
    kick(8'hA5, '0, '0, '0, '0);
    collect(model(8'hA5, '0, '0, '0, '0), 100, "R1 challenge top", OUT_BYTES);

    // R1 identifier only sits in the bottom byte of P
    kick('0, '0, 8'h3C, '0, '0);
    collect(model('0, '0, 8'h3C, '0, '0), 60, "R1 ident bottom", OUT_BYTES);

    // R5 done persists with no valid
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 done held", M_W'({done, out_valid}), M_W'(2'b10));
    out_ready = 1'b0;

    // R6 restart in mid stream
    kick(8'h11, 16'h2233, 8'h44, 40'h55_6677_8899, 32'hAABB_CCDD);
    collect(model(8'h11, 16'h2233, 8'h44, 40'h55_6677_8899, 32'hAABB_CCDD), 100, "R2 before restart", 3);
    c = 8'hF0; p = 16'h0F0F; d = 8'h81; r = 40'h12_3456_789A; n = 32'hFEDC_BA98;
    kick(c, p, d, r, n);
    collect(model(c, p, d, r, n), 70, "R6 restart", OUT_BYTES);

    // R6 inputs changed after start are ignored
    c = 8'h9E; p = 16'hC001; d = 8'h7B; r = 40'hDE_AD00_BEEF; n = 32'h8000_0001;
    e = model(c, p, d, r, n);
    kick(c, p, d, r, n);
    challenge = ~c; pad = ~p; ident = ~d; rand_mul = ~r; modulus = ~n;
    collect(e, 50, "R6 inputs ignored", OUT_BYTES);

    // R2 R4 random operands with random stalls
    for (int t = 0; t < 12; t++) begin
      c = CH_W'($urandom); p = PAD_W'($urandom); d = ID_W'($urandom);
      r = {8'($urandom), 32'($urandom)}; n = N_W'($urandom);
      kick(c, p, d, r, n);
      collect(model(c, p, d, r, n), (t % 2 == 0) ? 40 : 85, "R2 R4 random", OUT_BYTES);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule